// File: doc/BRIEF.md
# Serial PHY Tuning Write Sequencer

This block turns one write command into the bit-by-bit handshake that a PHY's internal tuning bits need. A command carries a start address, a data word of up to 32 bits, a bit count and a PHY index. The block owns a shared 32-bit control register. For every data bit, least significant first, it performs four register updates in order:

- put the current bit address into the address field;
- put the data bit into the data position and clear the selected strobe;
- set the strobe;
- clear the strobe again.

The address then steps by one for the next bit.

A command-time option first writes the whole register to zero before the first bit. While a transfer runs, the block reports busy. It refuses further commands with a one-cycle error pulse. It signals completion with a one-cycle done pulse.

Typical uses are a single-bit write, such as an enable at address 0x0C with value 1, and a multi-bit field write, such as five bits of 0x14 starting at address 0x20.

Top module: `phy_tune_writer`

## Requirements
- R1: Bits 15:8 of `ctlReg` hold the bit address. For bit i of a transfer this field is written with the start address plus i, modulo 256.
- R2: Bit 7 of `ctlReg` carries the data bit being written. Data bits go out least significant bit first.
- R3: The strobe for PHY n is bit 2·n of `ctlReg`, for n from 0 to 3. For each data bit the strobe is cleared together with the data update, then set, then cleared.
- R4: When `zeroFirst` is high at command acceptance, the whole register is written to 0 once, before the first address update.
- R5: Register bits outside bits 15:8, bit 7 and the selected strobe bit keep their values during a transfer, except for the zeroing of R4.
- R6: Consecutive register updates are HOLD+1 clock cycles apart. The first update follows acceptance by HOLD+1 cycles.
- R7: `busy` is high from the cycle after acceptance until the final strobe clear. `done` is high for exactly the one cycle that follows the final strobe clear, with `busy` low.
- R8: A command presented while busy is dropped without effect on the transfer in progress. `err` is high for the following cycle.
- R9: A command whose bit count is 0 or greater than 32 is not started. `err` is high for the following cycle and `ctlReg` is unchanged.
- R10: After reset `ctlReg` equals REG_INIT, and `busy`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request, sampled each clock |
| cmdAddr | input | 8 | Start bit address |
| cmdData | input | 32 | Data word, sent LSB first |
| cmdLen | input | 6 | Number of bits, 1 to 32 |
| cmdPhy | input | 2 | PHY index selecting the strobe bit |
| zeroFirst | input | 1 | Zero the whole register before the first bit |
| ctlReg | output | 32 | Shared control register |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a refused command |

## Verification
The hardest situation to reach from the ports is a command that collides with a transfer in progress. The second command must be dropped while the first one keeps its address, data and strobe sequence intact.

The bench launches a two-bit transfer and presents a conflicting command in the very next cycle. It then checks the error pulse, and checks that the final register holds the first command's last address, last data bit and a released strobe. Address wrap past 0xFF is reached with a 32-bit transfer that starts at 0xF0.

// File: rtl/phy_tune_pkg.sv
package phy_tune_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WIPE,
    PH_ADDR,
    PH_DATA,
    PH_RAISE,
    PH_DROP
  } phase_e;

  // One-cycle update strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new command
    logic wipe;     // zero the whole register
    logic putAddr;  // write current bit address
    logic putData;  // write data bit, clear strobe
    logic raise;    // set strobe
    logic drop;     // clear strobe, advance to next bit
  } tuneStb_t;

endpackage

// File: rtl/phy_tune_ctl.sv
module phy_tune_ctl
  import phy_tune_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HOLD   = 0,
  localparam int LEN_W  = $clog2(DATA_W + 1),
  localparam int HOLD_W = (HOLD > 0) ? $clog2(HOLD + 1) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [LEN_W-1:0] cmdLen,
  input  logic             zeroFirst,
  output tuneStb_t         stb,
  output logic             busy,
  output logic             done,
  output logic             err
);

  phase_e            phase;
  logic [LEN_W-1:0]  bitsLeft;
  logic [HOLD_W-1:0] holdCnt;
  logic              step;
  logic              lenOk;

  assign lenOk = (cmdLen != '0) && (cmdLen <= LEN_W'(DATA_W));
  assign step  = (holdCnt == HOLD_W'(HOLD));
  assign busy  = (phase != PH_IDLE);

  always_comb begin
    stb         = '0;
    stb.load    = (phase == PH_IDLE) && cmdValid && lenOk;
    stb.wipe    = (phase == PH_WIPE)  && step;
    stb.putAddr = (phase == PH_ADDR)  && step;
    stb.putData = (phase == PH_DATA)  && step;
    stb.raise   = (phase == PH_RAISE) && step;
    stb.drop    = (phase == PH_DROP)  && step;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitsLeft <= '0;
      holdCnt  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (phase == PH_IDLE) begin
        if (cmdValid) begin
          if (lenOk) begin
            phase    <= zeroFirst ? PH_WIPE : PH_ADDR;
            bitsLeft <= cmdLen;
            holdCnt  <= '0;
          end else begin
            err <= 1'b1;
          end
        end
      end else begin
        if (cmdValid) err <= 1'b1;
        if (step) begin
          holdCnt <= '0;
          unique case (phase)
            PH_WIPE:  phase <= PH_ADDR;
            PH_ADDR:  phase <= PH_DATA;
            PH_DATA:  phase <= PH_RAISE;
            PH_RAISE: phase <= PH_DROP;
            PH_DROP: begin
              bitsLeft <= bitsLeft - 1'b1;
              if (bitsLeft == LEN_W'(1)) begin
                phase <= PH_IDLE;
                done  <= 1'b1;
              end else begin
                phase <= PH_ADDR;
              end
            end
            default: phase <= PH_IDLE;
          endcase
        end else begin
          holdCnt <= holdCnt + 1'b1;
        end
      end
    end
  end

  // R8
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdValid) |=> err);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R7
  busy_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitsLeft != '0));

  // R9
  bad_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid && !lenOk) |=> (err && !busy));

endmodule

// File: rtl/phy_tune_dp.sv
module phy_tune_dp
  import phy_tune_pkg::*;
#(
  parameter int          REG_W    = 32,
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 8,
  parameter int          ADDR_LSB = 8,
  parameter int          DATA_BIT = 7,
  parameter int          PHYS     = 4,
  parameter logic [31:0] REG_INIT = 32'h5A3C_002A,
  localparam int PHY_W = (PHYS > 1) ? $clog2(PHYS) : 1,
  localparam int POS_W = $clog2(REG_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  tuneStb_t          stb,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [PHY_W-1:0]  cmdPhy,
  output logic [REG_W-1:0]  ctlReg
);

  logic [REG_W-1:0]  ctlQ;
  logic [ADDR_W-1:0] addrCur;
  logic [DATA_W-1:0] dataSh;
  logic [PHY_W-1:0]  phySel;
  logic [POS_W-1:0]  strobePos;
  logic [REG_W-1:0]  strobeMask;
  logic [REG_W-1:0]  fieldMask;
  logic [REG_W-1:0]  keepMask;

  assign strobePos  = POS_W'(phySel) << 1;
  assign strobeMask = REG_W'(1) << strobePos;
  assign fieldMask  = (((REG_W'(1) << ADDR_W) - 1'b1) << ADDR_LSB)
                    | (REG_W'(1) << DATA_BIT);
  assign keepMask   = ~(fieldMask | strobeMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ    <= REG_INIT[REG_W-1:0];
      addrCur <= '0;
      dataSh  <= '0;
      phySel  <= '0;
    end else begin
      if (stb.load) begin
        addrCur <= cmdAddr;
        dataSh  <= cmdData;
        phySel  <= cmdPhy;
      end
      if (stb.wipe) ctlQ <= '0;
      if (stb.putAddr) ctlQ[ADDR_LSB +: ADDR_W] <= addrCur;
      if (stb.putData) begin
        ctlQ[DATA_BIT]  <= dataSh[0];
        ctlQ[strobePos] <= 1'b0;
      end
      if (stb.raise) ctlQ[strobePos] <= 1'b1;
      if (stb.drop) begin
        ctlQ[strobePos] <= 1'b0;
        addrCur         <= addrCur + 1'b1;
        dataSh          <= dataSh >> 1;
      end
    end
  end

  assign ctlReg = ctlQ;

  // R5
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wipe |=> ((ctlQ & keepMask) == ($past(ctlQ) & keepMask)));

  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctlQ[6], ctlQ[4], ctlQ[2], ctlQ[0]}));

  // R3
  strobe_settled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|(ctlQ & strobeMask)) |->
      $stable(ctlQ[ADDR_LSB +: ADDR_W]) && $stable(ctlQ[DATA_BIT]));

endmodule

// File: rtl/phy_tune_writer.sv
module phy_tune_writer
  import phy_tune_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          HOLD     = 0,
  parameter logic [31:0] REG_INIT = 32'h5A3C_002A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic [7:0]  cmdAddr,
  input  logic [31:0] cmdData,
  input  logic [5:0]  cmdLen,
  input  logic [1:0]  cmdPhy,
  input  logic        zeroFirst,
  output logic [31:0] ctlReg,
  output logic        busy,
  output logic        done,
  output logic        err
);

  tuneStb_t stb;

  phy_tune_ctl #(
    .DATA_W (DATA_W),
    .HOLD   (HOLD)
  ) i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmdLen    (cmdLen),
    .zeroFirst (zeroFirst),
    .stb       (stb),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  phy_tune_dp #(
    .REG_W    (32),
    .DATA_W   (DATA_W),
    .ADDR_W   (8),
    .ADDR_LSB (8),
    .DATA_BIT (7),
    .PHYS     (4),
    .REG_INIT (REG_INIT)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cmdAddr (cmdAddr),
    .cmdData (cmdData),
    .cmdPhy  (cmdPhy),
    .ctlReg  (ctlReg)
  );

endmodule

// File: tb/test_phy_tune_writer.sv
module test_phy_tune_writer;

  localparam int          HOLD = 1;
  localparam logic [31:0] INIT = 32'h5A3C_002A;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic [5:0]  cmdLen = '0;
  logic [1:0]  cmdPhy = '0;
  logic        zeroFirst = 1'b0;
  logic [31:0] ctlReg;
  logic        busy, done, err;

  int errors = 0;
  int checks = 0;
  logic [31:0] model;

  always #4 clk = ~clk;

  phy_tune_writer #(.DATA_W(32), .HOLD(HOLD), .REG_INIT(INIT)) i_phy_tune_writer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdLen(cmdLen), .cmdPhy(cmdPhy), .zeroFirst(zeroFirst),
    .ctlReg(ctlReg), .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // advance to the next register update (R6 spacing) and sample mid-cycle
  task automatic step();
    repeat (HOLD + 1) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runCmd(input logic [7:0] addr, input logic [31:0] data,
                        input int len, input int phy, input logic zero);
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = addr; cmdData = data;
    cmdLen = 6'(len); cmdPhy = 2'(phy); zeroFirst = zero;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R7 busy after accept", {31'b0, busy}, 32'd1);
    if (zero) begin
      step();
      model = '0;
      chk("R4 register zeroed", ctlReg, model);
    end
    for (int i = 0; i < len; i++) begin
      step();
      model[15:8] = addr + 8'(i);
      chk("R1 address step", ctlReg, model);
      step();
      model[7] = data[i];
      model[2*phy] = 1'b0;
      chk("R2 data bit", ctlReg, model);
      step();
      model[2*phy] = 1'b1;
      chk("R3 strobe set", ctlReg, model);
      step();
      model[2*phy] = 1'b0;
      chk("R3 strobe clear", ctlReg, model);
      if (i == len - 1) begin
        chk("R7 done at end", {30'b0, done, busy}, 32'b10);
      end else begin
        chk("R7 busy mid transfer", {30'b0, done, busy}, 32'b01);
      end
    end
    @(negedge clk);
    chk("R7 done one cycle", {31'b0, done}, 32'd0);
  endtask

  task automatic resetCheck();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    model = INIT;
    chk("R10 reset register", ctlReg, INIT);
    chk("R10 reset flags", {29'b0, busy, done, err}, 32'd0);
  endtask

  task automatic timingCheck();
    // R6: no update during the hold cycle right after acceptance
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = 8'h33; cmdData = 32'h1; cmdLen = 6'd1;
    cmdPhy = 2'd0; zeroFirst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    repeat (HOLD) @(negedge clk);
    chk("R6 no early update", ctlReg, model);
    @(negedge clk);
    model[15:8] = 8'h33;
    chk("R6 first update", ctlReg, model);
    repeat (20) @(negedge clk);
    model[7] = 1'b1;
    chk("R6 transfer finished", ctlReg, model);
  endtask

  task automatic rejectBusy();
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = 8'h40; cmdData = 32'h2; cmdLen = 6'd2;
    cmdPhy = 2'd0; zeroFirst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cmdAddr = 8'h99; cmdData = 32'h0; cmdLen = 6'd1; cmdPhy = 2'd3;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R8 err on busy command", {31'b0, err}, 32'd1);
    @(negedge clk);
    chk("R8 err one cycle", {31'b0, err}, 32'd0);
    for (int k = 0; k < 100 && !done; k++) @(negedge clk);
    chk("R8 first command completed", {31'b0, done}, 32'd1);
    model[15:8] = 8'h41;
    model[7] = 1'b1;
    model[0] = 1'b0;
    chk("R8 register from first command only", ctlReg, model);
  endtask

  task automatic badLength(input int len);
    @(negedge clk);
    cmdValid = 1'b1; cmdAddr = 8'h11; cmdData = 32'hFFFF_FFFF;
    cmdLen = 6'(len); cmdPhy = 2'd1; zeroFirst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R9 err on bad length", {30'b0, err, busy}, 32'b10);
    repeat (4) @(negedge clk);
    chk("R9 register unchanged", ctlReg, model);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    resetCheck();
    runCmd(8'h0C, 32'h1, 1, 0, 1'b0);             // R1 R2 R3 single bit
    runCmd(8'h20, 32'h14, 5, 1, 1'b0);            // R2 LSB first, R5 odd bits kept
    runCmd(8'hF0, 32'hDEAD_BEEF, 32, 3, 1'b0);    // R1 address wrap
    timingCheck();
    rejectBusy();
    badLength(0);
    badLength(33);
    runCmd(8'h05, 32'h5, 3, 2, 1'b1);             // R4 zero first
    runCmd(8'h80, 32'h2, 2, 1, 1'b0);             // R5 after zeroing
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule